// File: doc/BRIEF.md
# Page Write Collector with Self-Timed Commit

This block sits between a two-wire serial slave engine and a non-volatile byte array. The slave engine hands it a start address, then the data bytes of a write transaction, then a commit strobe at the stop condition. The block gathers up to one page of bytes in a small local buffer, indexed by the low address bits. At commit it samples the write-protect input once. If protection is off, it runs a programming interval counted in clock cycles and then copies the gathered bytes into the array through a single write port.

The busy output stays high for the whole interval and for the copy that follows. While it is high, the slave engine must not acknowledge a device address. All strobes arriving during that time are dropped. The block also returns the value that the slave engine should use as the current address for a later current-address read. Only one strobe is expected per cycle. If several arrive together, the load-address strobe wins over the byte strobe, and the byte strobe wins over the commit strobe.

Top module: `pgwr_ctrl`

## Requirements
- R1: After reset `busy` and `mem_we` are 0 and `next_addr` is 0.
- R2: A `ld_addr` strobe taken while idle sets `next_addr` to `addr_in` on the following cycle.
- R3: Each `push` accepted after a load stores the byte at the in-page offset (address bits [2:0] with 8-byte pages). That offset then advances by one modulo the page size, and `next_addr` becomes the page bits joined with the advanced offset.
- R4: More pushes than the page holds wrap to the start of the same page. The array finally receives the last byte pushed for each offset.
- R5: A commit taken while idle, with at least one byte buffered and `wp` low, raises `busy` on the next cycle. `busy` then stays high for exactly PROG_CYCLES + PAGE_BYTES + 1 cycles.
- R6: Array writes happen only while `busy` is high and only after the interval. There is one write per loaded offset, in ascending address order, all inside one page. Offsets that were never loaded are not written.
- R7: A commit with no byte buffered (address only) raises no `busy` and produces no array write.
- R8: A commit with `wp` high produces no array write and no `busy`. The block takes a new load on the very next cycle.
- R9: `wp` is sampled only at the commit. Raising it during `busy` does not stop the array update.
- R10: While `busy` is high, `ld_addr`, `push` and `commit` are ignored. They change neither `next_addr`, the array, nor the length of the busy period.
- R11: A `push` that arrives when no address has been loaded since the last commit is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_addr | input | 1 | Strobe: take `addr_in` as start address |
| addr_in | input | AW | Start word address |
| push | input | 1 | Strobe: take `push_data` as next data byte |
| push_data | input | DW | Data byte |
| commit | input | 1 | Strobe: stop condition reached |
| wp | input | 1 | Write protect, sampled at commit |
| busy | output | 1 | Programming cycle in progress; slave must not acknowledge |
| next_addr | output | AW | Current address for the slave engine |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | AW | Array write address |
| mem_wdata | output | DW | Array write data |

## Verification
A wrong offset pointer shows up as `next_addr` one cycle after the push that caused it. It shows up again at the end of the busy period, as array writes landing at the wrong addresses or in the wrong count. A stale valid mask leaks bytes from an earlier transaction into a later page write. The bench catches this by comparing its shadow of the whole array after every transaction. A miscounted interval or a bad phase sequence is seen as a busy period of the wrong length. A protect or dummy path that starts a cycle is seen as `busy` rising in the cycle right after the commit.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_PROG  = 2'd1,
    PH_DRAIN = 2'd2,
    PH_FIN   = 2'd3
  } phase_e;
endpackage

// File: rtl/pgwr_buf.sv
module pgwr_buf #(
  parameter int DW         = 8,
  parameter int PAGE_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [$clog2(PAGE_BYTES)-1:0] wr_slot,
  input  logic [DW-1:0]                 wr_data,
  input  logic                          clr_mask,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_slot,
  output logic [DW-1:0]                 rd_data,
  output logic                          rd_valid,
  output logic                          any_valid
);
  localparam int OFFW = $clog2(PAGE_BYTES);

  logic [DW-1:0]         store [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask;

  // data storage without reset so it maps to small RAM
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_slot] <= wr_data;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst || clr_mask)                      mask[g] <= 1'b0;
      else if (wr_en && wr_slot == OFFW'(g))    mask[g] <= 1'b1;
    end
  end

  assign rd_data   = store[rd_slot];
  assign rd_valid  = mask[rd_slot];
  assign any_valid = |mask;
endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
  parameter int PROG_CYCLES = 625000
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CW = (PROG_CYCLES < 2) ? 1 : $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (load)             cnt <= LAST;
    else if (run && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq
  import pgwr_pkg::*;
#(
  parameter int PAGE_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic                          tmr_done,
  output phase_e                        phase,
  output logic [$clog2(PAGE_BYTES)-1:0] slot,
  output logic                          tmr_run
);
  localparam int OFFW = $clog2(PAGE_BYTES);
  localparam logic [OFFW-1:0] SLOT_LAST = OFFW'(PAGE_BYTES - 1);

  phase_e ph_d;

  always_comb begin
    ph_d = phase;
    unique case (phase)
      PH_IDLE:  if (start) ph_d = PH_PROG;
      PH_PROG:  if (tmr_done) ph_d = PH_DRAIN;
      PH_DRAIN: if (slot == SLOT_LAST) ph_d = PH_FIN;
      PH_FIN:   ph_d = PH_IDLE;
      default:  ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      slot  <= '0;
    end else begin
      phase <= ph_d;
      if (phase == PH_DRAIN) slot <= slot + 1'b1;
      else                   slot <= '0;
    end
  end

  assign tmr_run = (phase == PH_PROG);
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int AW          = 8,
  parameter int DW          = 8,
  parameter int PAGE_BYTES  = 8,
  parameter int PROG_CYCLES = 625000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_addr,
  input  logic [AW-1:0] addr_in,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          commit,
  input  logic          wp,
  output logic          busy,
  output logic [AW-1:0] next_addr,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);
  localparam int OFFW = $clog2(PAGE_BYTES);
  localparam int PGW  = AW - OFFW;

  phase_e          phase;
  logic [OFFW-1:0] slot;
  logic            tmr_run, tmr_done;
  logic [PGW-1:0]  page_q;
  logic [OFFW-1:0] ptr_q;
  logic            armed_q;
  logic [DW-1:0]   rd_data;
  logic            rd_valid, any_valid;
  logic            idle, acc_ld, acc_push, acc_commit, start_prog, clr_mask;

  assign idle       = (phase == PH_IDLE);
  assign acc_ld     = idle & ld_addr;
  assign acc_push   = idle & push & ~ld_addr & armed_q;
  assign acc_commit = idle & commit & ~ld_addr & ~push;
  assign start_prog = acc_commit & any_valid & ~wp;
  assign clr_mask   = acc_ld | (acc_commit & ~start_prog) | (phase == PH_FIN);

  // address pointer: page bits frozen, offset wraps within the page
  always_ff @(posedge clk) begin
    if (rst) begin
      page_q    <= '0;
      ptr_q     <= '0;
      armed_q   <= 1'b0;
      next_addr <= '0;
    end else begin
      if (acc_ld) begin
        page_q    <= addr_in[AW-1:OFFW];
        ptr_q     <= addr_in[OFFW-1:0];
        armed_q   <= 1'b1;
        next_addr <= addr_in;
      end else if (acc_push) begin
        ptr_q     <= ptr_q + 1'b1;
        next_addr <= {page_q, ptr_q + 1'b1};
      end else if (acc_commit) begin
        armed_q   <= 1'b0;
      end
    end
  end

  pgwr_buf #(.DW(DW), .PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (acc_push),
    .wr_slot  (ptr_q),
    .wr_data  (push_data),
    .clr_mask (clr_mask),
    .rd_slot  (slot),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .any_valid(any_valid)
  );

  pgwr_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
    .clk (clk),
    .rst (rst),
    .load(start_prog),
    .run (tmr_run),
    .done(tmr_done)
  );

  pgwr_seq #(.PAGE_BYTES(PAGE_BYTES)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start   (start_prog),
    .tmr_done(tmr_done),
    .phase   (phase),
    .slot    (slot),
    .tmr_run (tmr_run)
  );

  // registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      busy   <= start_prog | (phase == PH_PROG) | (phase == PH_DRAIN);
      mem_we <= (phase == PH_DRAIN) & rd_valid;
      if (phase == PH_DRAIN) begin
        mem_addr  <= {page_q, slot};
        mem_wdata <= rd_data;
      end
    end
  end
endmodule

// File: rtl/pgwr_chk.sv
module pgwr_chk #(
  parameter int AW          = 8,
  parameter int PAGE_BYTES  = 8,
  parameter int PROG_CYCLES = 625000
) (
  input logic          clk,
  input logic          rst,
  input logic          commit,
  input logic          wp,
  input logic          busy,
  input logic [AW-1:0] next_addr,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  localparam int OFFW = $clog2(PAGE_BYTES);
  localparam int SPAN = PROG_CYCLES + PAGE_BYTES + 1;

  int span;
  always_ff @(posedge clk) begin
    if (rst || !busy) span <= 0;
    else              span <= span + 1;
  end

  AST_BUSY_NEEDS_OPEN_COMMIT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(commit) && !$past(wp)));  // R5
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (span == SPAN));  // R5
  AST_WRITE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);  // R6
  AST_WRITE_ONE_PAGE_ASCENDING: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we)) |-> ((mem_addr[AW-1:OFFW] == $past(mem_addr[AW-1:OFFW])) && (mem_addr > $past(mem_addr))));  // R6
  AST_PROTECTED_NO_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (commit && wp && !busy) |=> !busy);  // R8
  AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(next_addr));  // R10
endmodule

bind pgwr_ctrl pgwr_chk #(.AW(AW), .PAGE_BYTES(PAGE_BYTES), .PROG_CYCLES(PROG_CYCLES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .commit   (commit),
  .wp       (wp),
  .busy     (busy),
  .next_addr(next_addr),
  .mem_we   (mem_we),
  .mem_addr (mem_addr)
);

// File: tb/sim_pgwr_ctrl.sv
`timescale 1ns/1ps
module sim_pgwr_ctrl;
  localparam int PROG = 24;
  localparam int SPAN = PROG + 8 + 1;
  localparam int NVEC = 6;
  // row: {start address, byte count, wp, data seed}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h10, 8'd1,  8'd0, 8'hA0},
    {8'h2D, 8'd5,  8'd0, 8'h30},
    {8'h48, 8'd8,  8'd0, 8'h51},
    {8'h63, 8'd11, 8'd0, 8'hC0},
    {8'h80, 8'd3,  8'd1, 8'h11},
    {8'hF0, 8'd0,  8'd0, 8'h00}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic ld_addr = 0, push = 0, commit = 0, wp = 0;
  logic [7:0] addr_in = 0, push_data = 0;
  logic busy, mem_we;
  logic [7:0] next_addr, mem_addr, mem_wdata;

  int n_chk = 0, n_bad = 0;
  int wr_total = 0, order_bad = 0;
  logic [7:0] arr [256];
  logic [7:0] exp_arr [256];
  logic [7:0] last_wr;
  logic       seen_wr;

  always #4 clk = ~clk;

  pgwr_ctrl #(.PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst(rst), .ld_addr(ld_addr), .addr_in(addr_in), .push(push),
    .push_data(push_data), .commit(commit), .wp(wp), .busy(busy),
    .next_addr(next_addr), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // shadow of the array, fed by the write port
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) arr[i] <= 8'hFF;
      seen_wr <= 1'b0;
    end else begin
      if (!busy) seen_wr <= 1'b0;
      if (mem_we) begin
        arr[mem_addr] <= mem_wdata;
        wr_total <= wr_total + 1;
        if (seen_wr && mem_addr <= last_wr) order_bad <= order_bad + 1;
        last_wr <= mem_addr;
        seen_wr <= 1'b1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cmp_arr(input string req);
    int bad = 0, first = -1;
    for (int i = 0; i < 256; i++)
      if (arr[i] !== exp_arr[i]) begin bad++; if (first < 0) first = i; end
    n_chk++;
    if (bad != 0) begin
      n_bad++;
      $display("FAIL %s: array @%0h actual %0h expected %0h", req, first, arr[first], exp_arr[first]);
    end
  endtask

  task automatic strobe_ld(input logic [7:0] a);
    ld_addr = 1; addr_in = a; @(negedge clk); ld_addr = 0;
  endtask
  task automatic strobe_push(input logic [7:0] d);
    push = 1; push_data = d; @(negedge clk); push = 0;
  endtask
  task automatic strobe_commit(input logic w);
    commit = 1; wp = w; @(negedge clk); commit = 0;
  endtask
  task automatic wait_idle(output int span);
    span = 0;
    while (busy && span < 1000) begin span++; @(negedge clk); end
  endtask

  task automatic run_txn(input logic [7:0] a, input int n, input logic w,
                         input logic [7:0] seed, output int span, output int writes);
    int w0 = wr_total;
    logic [7:0] seen = 0;
    strobe_ld(a);
    for (int i = 0; i < n; i++) begin
      strobe_push(seed + 8'(i));
      if (!w) exp_arr[{a[7:3], 3'(a[2:0] + i)}] = seed + 8'(i);
      seen[3'(a[2:0] + i)] = 1'b1;
    end
    strobe_commit(w);
    wait_idle(span);
    wp = 0;
    writes = wr_total - w0;
  endtask

  initial begin
    int span, writes, n;
    logic [7:0] a, seed;
    logic w;
    for (int i = 0; i < 256; i++) exp_arr[i] = 8'hFF;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 busy", busy, 0);
    chk("R1 mem_we", mem_we, 0);
    chk("R1 next_addr", next_addr, 0);
    rst = 0;
    @(negedge clk);

    // R11: push with no address loaded
    strobe_push(8'h99);
    strobe_commit(1'b0);
    chk("R11 busy after orphan push", busy, 0);
    chk("R11 next_addr", next_addr, 0);

    for (int v = 0; v < NVEC; v++) begin
      a = VEC[v][31:24]; n = int'(VEC[v][23:16]); w = VEC[v][8]; seed = VEC[v][7:0];
      run_txn(a, n, w, seed, span, writes);
      // R5 R7 R8: busy length
      chk($sformatf("R5/R7/R8 span v%0d", v), span, (n > 0 && !w) ? SPAN : 0);
      // R3 R4: next address
      chk($sformatf("R3 next_addr v%0d", v), next_addr,
          (n > 0) ? {a[7:3], 3'(a[2:0] + n)} : a);
      // R6: write count = loaded offsets
      chk($sformatf("R6 writes v%0d", v), writes, (w || n == 0) ? 0 : ((n > 8) ? 8 : n));
      cmp_arr($sformatf("R4/R6 array v%0d", v));
    end
    chk("R6 ascending order", order_bad, 0);

    // R2: load sets next_addr one cycle later
    strobe_ld(8'h5A);
    chk("R2 next_addr", next_addr, 8'h5A);
    // R7: dummy commit
    strobe_commit(1'b0);
    chk("R7 busy after dummy", busy, 0);

    // R8: protected commit then immediate new load
    strobe_ld(8'h90); strobe_push(8'h01); strobe_commit(1'b1);
    strobe_ld(8'h77);
    chk("R8 immediate load", next_addr, 8'h77);
    strobe_commit(1'b0);

    // R9: wp raised during busy does not cancel
    strobe_ld(8'h30); strobe_push(8'hE1); strobe_push(8'hE2);
    exp_arr[8'h30] = 8'hE1; exp_arr[8'h31] = 8'hE2;
    strobe_commit(1'b0);
    wp = 1;
    wait_idle(span);
    wp = 0;
    chk("R9 span", span, SPAN);
    cmp_arr("R9 array");

    // R10: strobes during busy ignored
    strobe_ld(8'h38); strobe_push(8'h5C);
    exp_arr[8'h38] = 8'h5C;
    strobe_commit(1'b0);
    strobe_ld(8'h05); strobe_push(8'h77); strobe_commit(1'b0);
    wait_idle(span);
    chk("R10 span", span + 3, SPAN);
    chk("R10 next_addr", next_addr, 8'h39);
    cmp_arr("R10 array");
    chk("R10 no busy after", busy, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule